// File: doc/BRIEF.md
# Interrupt-Capable Bidirectional GPIO Port

An 8-bit general-purpose port sits between a simple synchronous register bus and a row of pads. Each bit can be set on its own to drive its pad or to only observe it. Any bit can also latch an interrupt condition when its pad moves in the direction that software picks for it. Software reaches six registers through an address, a write strobe, write data and a combinational read-data path. The pads are seen through input, output and output-enable signals, one per bit.

Pad inputs pass through a two-flop synchronizer. The synchronized level is what software reads. Edges are found only by comparing that level with its own previous sample, so reprogramming the edge polarity cannot make an edge appear. Detected edges set sticky flags. A single interrupt request is active while any flag has its enable bit set. Every control bit exists for all eight bits, even if a product brings out fewer pins.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every readable register returns 0, all output enables are 0 and the interrupt request is 0.
- R2: The registers at addresses 1 (output data), 2 (direction), 3 (interrupt enable) and 4 (edge select) hold any 8-bit value that is written to them, and each reads back exactly. Addresses 6 and 7 read as 0.
- R3: The pad output of each bit equals its output-data bit. Its output enable equals its direction bit, where 1 means drive.
- R4: Address 0 returns the pad inputs after two clock edges of synchronization: a change is not visible after one edge and is visible after two. Writes to address 0 have no effect.
- R5: For each bit, an edge-select value of 0 flags a rising edge and a value of 1 flags a falling edge. The flag (address 5, same bit position) is readable after the third clock edge that follows the pad change. An edge of the other polarity does not set the flag.
- R6: A flag sets on its selected edge whether or not its interrupt enable is set.
- R7: The interrupt request is 1 exactly when some bit has both its flag and its enable at 1.
- R8: Writing to address 5 clears each flag whose write-data bit is 0. Flags whose write-data bit is 1 are left as they are and are never set by the write.
- R9: If a clearing write and a new edge on the same bit fall in the same clock cycle, the flag ends up set.
- R10: Changing the edge-select register while the pads are steady does not set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pad_in_i | input | 8 | Pad input levels (asynchronous) |
| pad_out_o | output | 8 | Pad output levels |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench sweeps all 256 input patterns and samples the input register after one edge and after two. A synchronizer that is too short or too long shows the new value at the wrong sample. Every bit is driven through a rising and a falling edge under both polarities. A swapped polarity, or a detector wired to the wrong bit, would set the flag on the wrong half of the pulse. A clearing write is timed into the exact cycle in which a new edge is detected. A design where the clear wins would lose that event, while another flag cleared by the same write must still drop. The edge-select register is toggled while the pads hold steady, which catches a detector that compares against the polarity instead of the previous sample. Writes of 1 to cleared flags must leave them at 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_IE   = 3'd3,
    REG_EDGE = 3'd4,
    REG_FLAG = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // polarity only picks which transition counts; it never feeds the compare
    assign hit[b] = fall_sel_i[b] ? (prev_q[b] & ~lvl_i[b])
                                  : (~prev_q[b] & lvl_i[b]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[b] <= 1'b0;
      else if (hit[b]) flag_q[b] <= 1'b1;
      else if (clr_i[b]) flag_q[b] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  in_i,
  input  logic [WIDTH-1:0]  flag_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  ie_o,
  output logic [WIDTH-1:0]  fall_sel_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] out_q, dir_q, ie_q, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      ie_q   <= '0;
      edge_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_OUT:  out_q  <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_IE:   ie_q   <= wdata_i;
        REG_EDGE: edge_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // write-zero-to-clear
  assign clr_o = (we_i && addr_i == REG_FLAG) ? ~wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_IN:   rdata_o = in_i;
      REG_OUT:  rdata_o = out_q;
      REG_DIR:  rdata_o = dir_q;
      REG_IE:   rdata_o = ie_q;
      REG_EDGE: rdata_o = edge_q;
      REG_FLAG: rdata_o = flag_i;
      default:  rdata_o = '0;
    endcase
  end

  assign out_o      = out_q;
  assign dir_o      = dir_q;
  assign ie_o       = ie_q;
  assign fall_sel_o = edge_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] ie_q;
  logic [WIDTH-1:0] fall_sel;
  logic [WIDTH-1:0] clr_mask;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  gpio_edge_flag #(.WIDTH(WIDTH)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (in_sync),
    .fall_sel_i(fall_sel),
    .clr_i     (clr_mask),
    .flag_o    (flag_q)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .in_i      (in_sync),
    .flag_i    (flag_q),
    .out_o     (pad_out_o),
    .dir_o     (pad_oe_o),
    .ie_o      (ie_q),
    .fall_sel_o(fall_sel),
    .clr_o     (clr_mask),
    .rdata_o   (rdata_o)
  );

  assign irq_o = |(flag_q & ie_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  pad_in_i,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic              irq_o,
  input logic [WIDTH-1:0]  in_sync,
  input logic [WIDTH-1:0]  flag_q,
  input logic [WIDTH-1:0]  ie_q
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_out_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_OUT) |=> pad_out_o == $past(wdata_i));

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DIR) |=> pad_oe_o == $past(wdata_i));

  p_sync_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> in_sync == $past(pad_in_i, 2));

  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q & ie_q) != '0);

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_FLAG) |=> (flag_q & $past(flag_q)) == $past(flag_q));

  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $stable(in_sync)) |=> (flag_q & ~$past(flag_q)) == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pad_in_i (pad_in_i),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .in_sync  (in_sync),
  .flag_q   (flag_q),
  .ie_q     (ie_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [7:0] pad_in_i = 8'h00;
  logic [7:0] pad_out_o;
  logic [7:0] pad_oe_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_IN = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2, A_IE = 3'd3,
                         A_EDGE = 3'd4, A_FLAG = 3'd5;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gpio_irq_port dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pad_in_i (pad_in_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .irq_o    (irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 8'h00);
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2/R3 register sweep
    for (int v = 0; v < 256; v++) begin
      wr(A_OUT, 8'(v));
      wr(A_DIR, ~8'(v));
      wr(A_IE, 8'(v ^ 8'h5A));
      wr(A_EDGE, 8'(255 - v));
      chk("R3 out", pad_out_o, 8'(v));
      chk("R3 oe", pad_oe_o, ~8'(v));
      rd("R2 out", A_OUT, 8'(v));
      rd("R2 dir", A_DIR, ~8'(v));
      rd("R2 ie", A_IE, 8'(v ^ 8'h5A));
      rd("R2 edge", A_EDGE, 8'(255 - v));
      chk("R7 no flags", {7'd0, irq_o}, 8'h00);
    end
    rd("R2 a6", 3'd6, 8'h00);
    rd("R2 a7", 3'd7, 8'h00);
    wr(A_IE, 8'h00);
    wr(A_EDGE, 8'h00);

    // R4 input sync latency sweep
    for (int v = 1; v < 256; v++) begin
      logic [7:0] old;
      old = pad_in_i;
      pad_in_i = 8'(v);
      tick(1);
      rd("R4 one edge", A_IN, old);
      tick(1);
      rd("R4 two edges", A_IN, 8'(v));
    end
    pad_in_i = 8'h00;
    tick(3);
    wr(A_IN, 8'hFF);
    rd("R4 write ignored", A_IN, 8'h00);
    rd("R4 out kept", A_OUT, 8'hFF);
    wr(A_FLAG, 8'h00);
    rd("R8 cleared", A_FLAG, 8'h00);

    // R5/R6 edge sweep, all bits, both polarities, interrupts disabled
    for (int b = 0; b < 8; b++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(A_EDGE, pol[0] ? 8'(1 << b) : 8'h00);
        pad_in_i[b] = 1'b1;
        tick(2);
        rd("R5 not yet", A_FLAG, 8'h00);
        tick(1);
        rd("R5 rise", A_FLAG, pol[0] ? 8'h00 : 8'(1 << b));
        pad_in_i[b] = 1'b0;
        tick(3);
        rd("R5 fall", A_FLAG, 8'(1 << b));
        chk("R6 irq off", {7'd0, irq_o}, 8'h00);
        wr(A_FLAG, 8'h00);
      end
    end
    wr(A_EDGE, 8'h00);

    // R6/R7 enable gating
    pad_in_i = 8'h48;
    tick(3);
    rd("R6 flags", A_FLAG, 8'h48);
    chk("R7 ie 0", {7'd0, irq_o}, 8'h00);
    wr(A_IE, 8'h08);
    chk("R7 ie match", {7'd0, irq_o}, 8'h01);
    wr(A_IE, 8'hB7);
    chk("R7 ie miss", {7'd0, irq_o}, 8'h00);
    wr(A_IE, 8'hFF);
    chk("R7 ie all", {7'd0, irq_o}, 8'h01);

    // R8 partial clear
    wr(A_FLAG, 8'h40);
    rd("R8 partial", A_FLAG, 8'h40);
    chk("R7 remains", {7'd0, irq_o}, 8'h01);
    wr(A_FLAG, 8'h00);
    chk("R7 none", {7'd0, irq_o}, 8'h00);
    wr(A_FLAG, 8'hFF);
    rd("R8 write one", A_FLAG, 8'h00);

    // R9 clear and edge in the same cycle
    pad_in_i = 8'h00;
    tick(3);
    wr(A_FLAG, 8'h00);
    pad_in_i[5] = 1'b1;
    tick(3);
    rd("R9 setup", A_FLAG, 8'h20);
    pad_in_i[2] = 1'b1;
    tick(2);
    wr(A_FLAG, 8'h00);
    rd("R9 edge wins", A_FLAG, 8'h04);

    // R10 edge select change with steady pads
    pad_in_i = 8'hA5;
    tick(3);
    wr(A_FLAG, 8'h00);
    wr(A_EDGE, 8'hFF);
    tick(2);
    rd("R10 to fall", A_FLAG, 8'h00);
    wr(A_EDGE, 8'h00);
    tick(2);
    rd("R10 to rise", A_FLAG, 8'h00);
    chk("R10 irq", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule